// File: doc/BRIEF.md
# Flash Serial Clock and Chip-Select Timer

This block generates the serial clock for an external flash link from the system clock and drives two active-low chip-select lines. An 8-bit divide setting P gives one serial period every P+1 system cycles. A 3-bit gap setting H sets a minimum time, counted in serial periods, that the chip selects stay high between two commands. A mode bit picks whether the serial clock idles low (mode 0) or high (mode 3). A select bit picks which of the two devices a command drives.

A command sequencer starts a command with a valid/ready handshake on `cmd_valid`/`cmd_ready`. `cmd_ready` is high only when the block is enabled and the previous gap has run out. A start is accepted on a clock edge where both are high, and `dev_sel` is sampled on that edge. `cmd_valid` may be held high while `cmd_ready` is low. Nothing happens until `cmd_ready` rises, and the sequencer must not treat a start as taken before that edge.

The sequencer ends a command with a one-cycle `cmd_end` strobe. While a command runs, the block emits `sclk_tick` once per serial period, on the leading-edge cycle. The data shifter uses this tick as its clock enable. Divide, gap and mode settings may change only while `cmd_ready` is high or the block is disabled.

Top module: `fclk_cs_timing`

## Requirements
- R1: After reset both chip selects are high, `sclk_tick` is 0, `sclk` sits at the idle level and `cmd_ready` equals `cfg_enable`.
- R2: In the first cycle after an accepted start, `sclk_tick` is 1. It is then 1 once every P+1 system cycles for as long as the command runs, and 0 otherwise.
- R3: For P of 1 or more, each serial period starts with a leading phase at the level opposite to idle. In mode 0 the leading phase lasts ceil((P+1)/2) cycles. In mode 3 it lasts floor((P+1)/2) cycles. So an odd ratio always puts its extra cycle in the high phase.
- R4: With P equal to 0, `sclk` changes level on every system cycle of a command, starting at the level opposite to idle, and `sclk_tick` is 1 on every cycle.
- R5: Whenever the block is enabled and no chip select is low, `sclk` equals `cfg_idle_high`. That is 0 in mode 0 and 1 in mode 3.
- R6: From the cycle after an accepted start, `cs_n[dev_sel]` is low and the other line is high (bit 0 selects device 0, bit 1 device 1). The same line stays low until the command ends.
- R7: When `cmd_end` is sampled during a command, both chip selects are high in the next cycle. `cmd_ready` then stays low for exactly (H+1)*(P+1) cycles and rises in the cycle after.
- R8: `cmd_valid` while `cmd_ready` is low starts nothing: both chip selects stay high.
- R9: While `cfg_enable` is 0, both chip selects are high and `cmd_ready` is 0 in the same cycle. Clearing it during a command ends the command and starts the gap of R7.
- R10: At most one chip select is low at any time, and never while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global enable; 0 forces both chip selects high |
| cfg_div | input | 8 | Divide setting P, serial period = P+1 cycles |
| cfg_gap | input | 3 | Gap setting H, minimum high time = H+1 serial periods |
| cfg_idle_high | input | 1 | 0: clock idles low (mode 0), 1: idles high (mode 3) |
| dev_sel | input | 1 | Device chosen by the next start |
| cmd_valid | input | 1 | Start request |
| cmd_ready | output | 1 | Start can be accepted |
| cmd_end | input | 1 | End-of-command strobe |
| sclk | output | 1 | Serial clock |
| sclk_tick | output | 1 | One pulse per serial period on the leading-edge cycle |
| cs_n | output | 2 | Active-low chip selects |

## Verification
Chip selects, `sclk`, `sclk_tick` and `cmd_ready` come from one state register, so each of them answers a sampled start, end or enable change in the cycle right after that edge. The one exception is `cfg_enable`, which acts on the chip selects and on `cmd_ready` in the same cycle. The gap result is due exactly (H+1)*(P+1) cycles after the chip selects rise. The bench steps one cycle at a time and samples 2 ns after each rising edge. It counts active and gap cycles from the first cycle after the edge that took the stimulus, and compares every sampled cycle with the value its reference functions give for that index. Random divide, gap, mode, device and length settings are mixed with directed cases at P = 0, P = 255 and with enable cleared mid-command.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
  typedef enum logic [1:0] {
    LNK_READY  = 2'd0,
    LNK_ACTIVE = 2'd1,
    LNK_GAP    = 2'd2
  } link_state_t;
endpackage

// File: rtl/fclk_phase_cnt.sv
// Position counter inside one serial period: counts 0..div, then wraps.
module fclk_phase_cnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] phase,
  output logic             wrap
);
  assign wrap = run && (phase == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (!run || restart)  phase <= '0;
    else if (phase == div)     phase <= '0;
    else                       phase <= phase + 1'b1;
  end
endmodule

// File: rtl/fclk_shaper.sv
// Builds the serial clock level from the period position.
module fclk_shaper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             idle_high,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] phase,
  output logic             sclk
);
  localparam int EXT_W = DIV_W + 1;

  logic             half_q;
  logic [EXT_W-1:0] div_ext;
  logic [EXT_W-1:0] lead_len;
  logic             lead_phase;

  // P = 0: level flips each system cycle, first cycle is leading.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (!active) half_q <= 1'b0;
    else              half_q <= ~half_q;
  end

  always_comb begin
    div_ext  = {1'b0, div};
    // Leading phase is high in mode 0, low in mode 3: high phase takes the odd cycle.
    lead_len = idle_high ? ((div_ext + EXT_W'(1)) >> 1)
                         : ((div_ext + EXT_W'(2)) >> 1);
    if (div == '0) lead_phase = ~half_q;
    else           lead_phase = ({1'b0, phase} < lead_len);
    sclk = idle_high ^ (active & lead_phase);
  end
endmodule

// File: rtl/fclk_gap_timer.sv
// Counts serial periods while chip selects are held high between commands.
module fclk_gap_timer #(
  parameter int GAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             counting,
  input  logic             wrap,
  input  logic [GAP_W-1:0] gap,
  output logic             done
);
  logic [GAP_W-1:0] periods_q;

  assign done = counting && wrap && (periods_q == gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         periods_q <= '0;
    else if (!counting) periods_q <= '0;
    else if (wrap)      periods_q <= periods_q + 1'b1;
  end
endmodule

// File: rtl/fclk_cs_timing.sv
module fclk_cs_timing #(
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 3,
  parameter int NUM_CS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_enable,
  input  logic [DIV_W-1:0]          cfg_div,
  input  logic [GAP_W-1:0]          cfg_gap,
  input  logic                      cfg_idle_high,
  input  logic [$clog2(NUM_CS)-1:0] dev_sel,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_end,
  output logic                      sclk,
  output logic                      sclk_tick,
  output logic [NUM_CS-1:0]         cs_n
);
  import fclk_pkg::*;

  localparam int SEL_W = $clog2(NUM_CS);

  link_state_t      state_q, state_d;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] phase;
  logic             wrap;
  logic             gap_done;
  logic             accept;
  logic             leave_active;
  logic             in_active;

  assign in_active    = (state_q == LNK_ACTIVE);
  assign cmd_ready    = (state_q == LNK_READY) && cfg_enable;
  assign accept       = cmd_valid && cmd_ready;
  assign leave_active = in_active && (cmd_end || !cfg_enable);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LNK_READY:  if (accept)       state_d = LNK_ACTIVE;
      LNK_ACTIVE: if (leave_active) state_d = LNK_GAP;
      LNK_GAP:    if (gap_done)     state_d = LNK_READY;
      default:                      state_d = LNK_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LNK_READY;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) sel_q <= dev_sel;
    end
  end

  fclk_phase_cnt #(.DIV_W(DIV_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q != LNK_READY),
    .restart (leave_active),
    .div     (cfg_div),
    .phase   (phase),
    .wrap    (wrap)
  );

  fclk_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .counting (state_q == LNK_GAP),
    .wrap     (wrap),
    .gap      (cfg_gap),
    .done     (gap_done)
  );

  fclk_shaper #(.DIV_W(DIV_W)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_active),
    .idle_high (cfg_idle_high),
    .div       (cfg_div),
    .phase     (phase),
    .sclk      (sclk)
  );

  assign sclk_tick = in_active && (phase == '0);

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    assign cs_n[gi] = !(cfg_enable && in_active && (sel_q == SEL_W'(gi)));
  end
endmodule

// File: rtl/fclk_cs_timing_chk.sv
module fclk_cs_timing_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_idle_high,
  input logic              cmd_ready,
  input logic              sclk,
  input logic              sclk_tick,
  input logic [NUM_CS-1:0] cs_n
);
  a_r10_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r10_ready_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (cs_n == '1));

  a_r9_disable_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (cs_n == '1 && !cmd_ready));

  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cs_n == '1) |-> (sclk == cfg_idle_high && !sclk_tick));

  a_r6_same_device: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && $past(cs_n != '1)) |-> $stable(cs_n));
endmodule

bind fclk_cs_timing fclk_cs_timing_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_idle_high (cfg_idle_high),
  .cmd_ready     (cmd_ready),
  .sclk          (sclk),
  .sclk_tick     (sclk_tick),
  .cs_n          (cs_n)
);

// File: tb/fclk_cs_timing_tb.sv
module fclk_cs_timing_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b1;
  logic [7:0] cfg_div = '0;
  logic [2:0] cfg_gap = '0;
  logic       cfg_idle_high = 1'b0;
  logic       dev_sel = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic       cmd_end = 1'b0;
  logic       sclk;
  logic       sclk_tick;
  logic [1:0] cs_n;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  fclk_cs_timing dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_div(cfg_div),
    .cfg_gap(cfg_gap), .cfg_idle_high(cfg_idle_high), .dev_sel(dev_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_end(cmd_end),
    .sclk(sclk), .sclk_tick(sclk_tick), .cs_n(cs_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  function automatic bit exp_sclk(int p, bit m, int c);
    int fl;
    bit lead;
    fl = m ? (p + 1) / 2 : (p + 2) / 2;
    if (p == 0) lead = (c % 2) == 0;
    else        lead = (c % (p + 1)) < fl;
    return m ^ lead;
  endfunction

  function automatic logic [1:0] exp_cs(bit sel);
    return sel ? 2'b01 : 2'b10;
  endfunction

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic run_cmd(int p, int h, bit m, bit sel, int len);
    int g_len;
    cfg_div = 8'(p); cfg_gap = 3'(h); cfg_idle_high = m;
    dev_sel = sel; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) cyc();
    cyc();
    cmd_valid = 1'b0;
    for (int c = 0; c < len; c++) begin
      check(cs_n == exp_cs(sel), "R6 cs select", cs_n, exp_cs(sel));
      check(sclk_tick == ((c % (p + 1)) == 0), "R2 tick period", sclk_tick,
            int'((c % (p + 1)) == 0));
      if (p == 0) check(sclk == exp_sclk(p, m, c), "R4 fast clock", sclk, exp_sclk(p, m, c));
      else        check(sclk == exp_sclk(p, m, c), "R3 duty", sclk, exp_sclk(p, m, c));
      if (c == len - 1) cmd_end = 1'b1;
      cyc();
    end
    cmd_end = 1'b0;
    cmd_valid = 1'b1;
    dev_sel = ~sel;
    g_len = (h + 1) * (p + 1);
    for (int g = 0; g < g_len; g++) begin
      check(cs_n == 2'b11, "R8 cs high in gap", cs_n, 3);
      check(cmd_ready == 1'b0, "R7 ready low in gap", cmd_ready, 0);
      check(sclk == m, "R5 idle level", sclk, m);
      cyc();
    end
    check(cmd_ready == 1'b1, "R7 ready after gap", cmd_ready, 1);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(cs_n == 2'b11, "R1 reset cs", cs_n, 3);
    check(sclk_tick == 1'b0, "R1 reset tick", sclk_tick, 0);
    check(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    check(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    cyc();

    run_cmd(0, 0, 1'b0, 1'b0, 6);
    run_cmd(0, 2, 1'b1, 1'b1, 5);
    run_cmd(1, 1, 1'b0, 1'b1, 8);
    run_cmd(2, 0, 1'b0, 1'b0, 9);
    run_cmd(2, 3, 1'b1, 1'b0, 9);
    run_cmd(4, 7, 1'b1, 1'b1, 12);
    run_cmd(255, 7, 1'b0, 1'b0, 600);

    for (int k = 0; k < 14; k++) begin
      int p;
      p = int'($urandom_range(0, 9));
      run_cmd(p, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), int'($urandom_range(1, 24)));
    end

    // R9: enable cleared mid-command
    cfg_div = 8'd3; cfg_gap = 3'd1; cfg_idle_high = 1'b0;
    dev_sel = 1'b1; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) cyc();
    cyc();
    cmd_valid = 1'b0;
    check(cs_n == 2'b01, "R9 active before disable", cs_n, 1);
    cyc(); cyc();
    cfg_enable = 1'b0;
    #1;
    check(cs_n == 2'b11, "R9 disable forces cs high", cs_n, 3);
    check(cmd_ready == 1'b0, "R9 disable ready low", cmd_ready, 0);
    cmd_valid = 1'b1;
    repeat (20) cyc();
    check(cs_n == 2'b11, "R9 stays high while disabled", cs_n, 3);
    check(cmd_ready == 1'b0, "R9 no ready while disabled", cmd_ready, 0);
    cmd_valid = 1'b0;
    cfg_enable = 1'b1;
    #1;
    check(cmd_ready == 1'b1, "R9 ready on re-enable", cmd_ready, 1);
    cyc();
    check(cs_n == 2'b11, "R8 no start without valid", cs_n, 3);

    report();
    $finish;
  end
endmodule